// File: doc/BRIEF.md
# Reed-Solomon Symbol Error Applier for a Flash Page Buffer

This block takes the output of a Reed-Solomon decoder that works on 12-bit symbols and applies it to a page held in a byte-wide buffer RAM. The decoder hands over up to four error locations, each with a 12-bit error value. The page lies in the buffer as 2048 data bytes. The spare bytes follow at buffer address 2048 + k for spare byte k. Each symbol position maps to one or two bytes, and the error value is split into nibble-aligned pieces that are XORed into those bytes through read-modify-write cycles.

A job starts with one `start_i` pulse while the block is idle. All error pairs and their count arrive on parallel ports in that same cycle. The block steps through the pairs in index order and performs the XORs. It then pulses `done_o` and reports either the number of corrected symbols or a failure. A position beyond the end of the protected codeword fails the job. So does a leading half-symbol whose error value has bits above the low byte. On a failure, pairs with a lower index have already been applied and the remaining pairs are skipped.

Top module: `rs_byte_fixer`

## Requirements
- R1: While reset is held, and after it is released, the block is idle: `busy_o`, `done_o`, `fail_o` and `mem_en_o` are 0 and `count_o` is 0.
- R2: `start_i` is accepted only when `busy_o` is 0, and all ports are sampled at that edge. `done_o` is a one-cycle pulse. It becomes visible 2 + 2·B cycles after the cycle in which `start_i` was driven, where B is the number of bytes updated. `busy_o` is low while `done_o` is high.
- R3: An odd position p with 0 < p < 1365 XORs value[11:4] into byte floor(3p/2) and then {value[3:0], 4'h0} into byte floor(3p/2)+1.
- R4: An even position p with 0 < p < 1365 XORs {4'h0, value[11:8]} into byte 3p/2−1 and then value[7:0] into byte 3p/2.
- R5: Position 0 holds only 8 data bits. If value[11:8] is 0, value[7:0] is XORed into byte 0. Otherwise the job fails and byte 0 is not written.
- R6: Position 1365 XORs value[11:4] into data byte 2047 and then {value[3:0], 4'h0} into spare byte 0 (address 2048). No access ever goes to an address of 2112 or above.
- R7: Positions 1366 to 1374 use the odd and even rules of R3 and R4 with the byte index reduced by 2048, and that index selects a spare byte (address 2048 + index).
- R8: A position above 1374 fails the job.
- R9: On a failure, pairs with a lower index stay applied. The failing pair and all later pairs write nothing. `fail_o` is 1 and `count_o` is 0.
- R10: On success `fail_o` is 0 and `count_o` equals `num_i`. Both outputs hold until the next accepted start.
- R11: Each byte update is a read cycle (`mem_en_o`=1, `mem_we_o`=0) followed in the next cycle by a write cycle to the same address. The write data is the read data XOR the mask. Pairs are applied in index order, the lower byte of each pair first. There is no buffer access while `busy_o` is 0.
- R12: A `num_i` greater than 4 fails the job with no buffer access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a job (taken when idle) |
| num_i | input | 3 | Number of error pairs |
| pos_i | input | 4×11 | Symbol positions, entry k used k-th |
| pat_i | input | 4×12 | Error values, paired with `pos_i` |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle end-of-job pulse |
| fail_o | output | 1 | Last job failed |
| count_o | output | 3 | Symbols corrected by the last job |
| mem_en_o | output | 1 | Buffer access enable |
| mem_we_o | output | 1 | Buffer write (read when 0) |
| mem_addr_o | output | 12 | Buffer byte address |
| mem_wdata_o | output | 8 | Buffer write data |
| mem_rdata_i | input | 8 | Buffer read data, one cycle after the read |

## Verification
Some properties are checked on every cycle. Every write is preceded by a read of the same address. Every read is followed by a write. The buffer stays quiet while idle and no address leaves the page. `done_o` is a single-cycle pulse, and a failure never reports a non-zero count. The bench scenarios cover everything else: the byte addresses and nibble masks for odd, even, zero, boundary-straddling and spare-area positions, repeated hits on one byte, partial application before a failure, and the done latency. These are checked against a reference model of the buffer.

// File: rtl/rsfix_pkg.sv
`timescale 1ns/1ps
package rsfix_pkg;
  localparam int SYM_W  = 12;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR
  } seq_st_e;
endpackage

// File: rtl/rsfix_map.sv
`timescale 1ns/1ps
module rsfix_map
  import rsfix_pkg::*;
#(
  parameter int POS_W   = 11,
  parameter int ADDR_W  = 12,
  parameter int MAX_POS = 1374
) (
  input  logic [POS_W-1:0]  pos_i,
  input  logic [SYM_W-1:0]  pat_i,
  output logic [ADDR_W-1:0] addr0_o,
  output logic [ADDR_W-1:0] addr1_o,
  output logic [BYTE_W-1:0] mask0_o,
  output logic [BYTE_W-1:0] mask1_o,
  output logic              two_o,
  output logic              bad_o
);
  // byte offset of symbol p is floor(3p/2)
  logic [POS_W+1:0]  tri_w;
  logic [ADDR_W-1:0] half_w;

  assign tri_w  = {2'b00, pos_i} + {1'b0, pos_i, 1'b0};
  assign half_w = ADDR_W'(tri_w[POS_W+1:1]);

  always_comb begin
    addr0_o = '0;
    addr1_o = '0;
    mask0_o = '0;
    mask1_o = '0;
    two_o   = 1'b0;
    if (pos_i == '0) begin
      mask0_o = pat_i[7:0];
    end else if (pos_i[0]) begin
      addr0_o = half_w;
      addr1_o = half_w + ADDR_W'(1);
      mask0_o = pat_i[11:4];
      mask1_o = {pat_i[3:0], 4'h0};
      two_o   = 1'b1;
    end else begin
      addr0_o = half_w - ADDR_W'(1);
      addr1_o = half_w;
      mask0_o = {4'h0, pat_i[11:8]};
      mask1_o = pat_i[7:0];
      two_o   = 1'b1;
    end
  end

  assign bad_o = (int'(pos_i) > MAX_POS) || ((pos_i == '0) && (pat_i[11:8] != 4'h0));
endmodule

// File: rtl/rsfix_seq.sv
`timescale 1ns/1ps
module rsfix_seq
  import rsfix_pkg::*;
#(
  parameter int MAX_ERR = 4,
  parameter int ADDR_W  = 12,
  parameter int CNT_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [CNT_W-1:0]  num_i,
  input  logic [ADDR_W-1:0] addr0_i,
  input  logic [ADDR_W-1:0] addr1_i,
  input  logic [BYTE_W-1:0] mask0_i,
  input  logic [BYTE_W-1:0] mask1_i,
  input  logic              two_i,
  input  logic              bad_i,
  output logic [CNT_W-1:0]  idx_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [CNT_W-1:0]  count_o
);
  seq_st_e          state_q;
  logic [CNT_W-1:0] idx_q, num_q, count_q;
  logic             hi_q, done_q, fail_q;

  logic over_num, at_end, stop_fail, stop_ok;

  assign over_num  = int'(num_q) > MAX_ERR;
  assign at_end    = idx_q == num_q;
  assign stop_fail = over_num || (!at_end && bad_i);
  assign stop_ok   = !over_num && at_end;

  assign mem_addr_o  = hi_q ? addr1_i : addr0_i;
  assign mem_wdata_o = mem_rdata_i ^ (hi_q ? mask1_i : mask0_i);
  assign mem_we_o    = state_q == ST_WR;
  assign mem_en_o    = (state_q == ST_WR) || ((state_q == ST_RD) && !stop_fail && !stop_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      num_q   <= '0;
      count_q <= '0;
      hi_q    <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_i) begin
            num_q   <= num_i;
            idx_q   <= '0;
            hi_q    <= 1'b0;
            fail_q  <= 1'b0;
            count_q <= '0;
            state_q <= ST_RD;
          end
        end
        ST_RD: begin
          if (stop_fail) begin
            done_q  <= 1'b1;
            fail_q  <= 1'b1;
            count_q <= '0;
            state_q <= ST_IDLE;
          end else if (stop_ok) begin
            done_q  <= 1'b1;
            fail_q  <= 1'b0;
            count_q <= num_q;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_WR;
          end
        end
        ST_WR: begin
          if (!hi_q && two_i) begin
            hi_q <= 1'b1;
          end else begin
            hi_q  <= 1'b0;
            idx_q <= idx_q + CNT_W'(1);
          end
          state_q <= ST_RD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idx_o   = idx_q;
  assign busy_o  = state_q != ST_IDLE;
  assign done_o  = done_q;
  assign fail_o  = fail_q;
  assign count_o = count_q;
endmodule

// File: rtl/rs_byte_fixer.sv
`timescale 1ns/1ps
module rs_byte_fixer
  import rsfix_pkg::*;
#(
  parameter int MAX_ERR     = 4,
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int ECC_BYTES   = 14,
  localparam int TOTAL      = DATA_BYTES + SPARE_BYTES,
  localparam int ADDR_W     = $clog2(TOTAL),
  // leading half-symbol carries SYM_W-8 padding bits
  localparam int MAX_POS    = ((DATA_BYTES + ECC_BYTES) * 8 + (SYM_W - 8)) / SYM_W - 1,
  localparam int POS_W      = $clog2(MAX_POS + 1),
  localparam int CNT_W      = $clog2(MAX_ERR + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [CNT_W-1:0]              num_i,
  input  logic [MAX_ERR-1:0][POS_W-1:0] pos_i,
  input  logic [MAX_ERR-1:0][SYM_W-1:0] pat_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          fail_o,
  output logic [CNT_W-1:0]              count_o,
  output logic                          mem_en_o,
  output logic                          mem_we_o,
  output logic [ADDR_W-1:0]             mem_addr_o,
  output logic [BYTE_W-1:0]             mem_wdata_o,
  input  logic [BYTE_W-1:0]             mem_rdata_i
);
  logic [MAX_ERR-1:0][POS_W-1:0]  pos_q;
  logic [MAX_ERR-1:0][SYM_W-1:0]  pat_q;
  logic [MAX_ERR-1:0][ADDR_W-1:0] a0_w, a1_w;
  logic [MAX_ERR-1:0][BYTE_W-1:0] m0_w, m1_w;
  logic [MAX_ERR-1:0]             two_w, bad_w;

  logic              accept;
  logic [CNT_W-1:0]  idx;
  logic [ADDR_W-1:0] cur_a0, cur_a1;
  logic [BYTE_W-1:0] cur_m0, cur_m1;
  logic              cur_two, cur_bad;

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      pat_q <= '0;
    end else if (accept) begin
      pos_q <= pos_i;
      pat_q <= pat_i;
    end
  end

  for (genvar g = 0; g < MAX_ERR; g++) begin : g_map
    rsfix_map #(
      .POS_W  (POS_W),
      .ADDR_W (ADDR_W),
      .MAX_POS(MAX_POS)
    ) map_i (
      .pos_i  (pos_q[g]),
      .pat_i  (pat_q[g]),
      .addr0_o(a0_w[g]),
      .addr1_o(a1_w[g]),
      .mask0_o(m0_w[g]),
      .mask1_o(m1_w[g]),
      .two_o  (two_w[g]),
      .bad_o  (bad_w[g])
    );
  end

  always_comb begin
    cur_a0  = '0;
    cur_a1  = '0;
    cur_m0  = '0;
    cur_m1  = '0;
    cur_two = 1'b0;
    cur_bad = 1'b0;
    for (int k = 0; k < MAX_ERR; k++) begin
      if (int'(idx) == k) begin
        cur_a0  = a0_w[k];
        cur_a1  = a1_w[k];
        cur_m0  = m0_w[k];
        cur_m1  = m1_w[k];
        cur_two = two_w[k];
        cur_bad = bad_w[k];
      end
    end
  end

  rsfix_seq #(
    .MAX_ERR(MAX_ERR),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) seq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .num_i      (num_i),
    .addr0_i    (cur_a0),
    .addr1_i    (cur_a1),
    .mask0_i    (cur_m0),
    .mask1_i    (cur_m1),
    .two_i      (cur_two),
    .bad_i      (cur_bad),
    .idx_o      (idx),
    .mem_en_o   (mem_en_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .count_o    (count_o)
  );
endmodule

// File: rtl/rsfix_chk.sv
`timescale 1ns/1ps
module rsfix_chk #(
  parameter int MAX_ERR = 4,
  parameter int TOTAL   = 2112,
  parameter int ADDR_W  = 12,
  parameter int CNT_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_en_o);

  assert_write_after_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && mem_we_o) |-> ($past(mem_en_o && !mem_we_o) && ($past(mem_addr_o) == mem_addr_o)));

  assert_read_then_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && !mem_we_o) |=> (mem_en_o && mem_we_o));

  assert_addr_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> (int'(mem_addr_o) < TOTAL));

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_fail_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (count_o == '0));

  assert_count_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_o) <= MAX_ERR);
endmodule

bind rs_byte_fixer rsfix_chk #(
  .MAX_ERR(MAX_ERR),
  .TOTAL  (TOTAL),
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .fail_o    (fail_o),
  .count_o   (count_o),
  .mem_en_o  (mem_en_o),
  .mem_we_o  (mem_we_o),
  .mem_addr_o(mem_addr_o)
);

// File: tb/rs_byte_fixer_tb_top.sv
`timescale 1ns/1ps
module rs_byte_fixer_tb_top;
  localparam int NE    = 4;
  localparam int TOTAL = 2112;
  localparam int MAXP  = 1374;
  localparam int PW    = 11;
  localparam int AW    = 12;
  localparam int CW    = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                    rst_n;
  logic                    start;
  logic [CW-1:0]           num;
  logic [NE-1:0][PW-1:0]   pos_v;
  logic [NE-1:0][11:0]     pat_v;
  logic                    busy, done, fail;
  logic [CW-1:0]           count;
  logic                    mem_en, mem_we;
  logic [AW-1:0]           mem_addr;
  logic [7:0]              mem_wdata, mem_rdata;

  rs_byte_fixer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .num_i(num),
    .pos_i(pos_v), .pat_i(pat_v), .busy_o(busy), .done_o(done),
    .fail_o(fail), .count_o(count), .mem_en_o(mem_en), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  logic [7:0] ram [TOTAL];
  logic [7:0] ref_ram [TOTAL];

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata     <= ram[mem_addr];
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int addr; int data; string tag; } wr_t;
  typedef struct { bit fl; int cnt; int due; string tag; } res_t;
  wr_t  wq[$];
  res_t rq[$];

  int total = 0;
  int bad   = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=0x%0h exp=0x%0h", tag, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    wr_t  w;
    res_t r;
    if (rst_n) begin
      if (mem_en && mem_we) begin
        if (wq.size() == 0) chk(1'b0, "R11", "unexpected write", int'(mem_addr), -1);
        else begin
          w = wq.pop_front();
          chk(int'(mem_addr) == w.addr, w.tag, "write addr", int'(mem_addr), w.addr);
          chk(int'(mem_wdata) == w.data, w.tag, "write data", int'(mem_wdata), w.data);
        end
      end
      if (done) begin
        if (rq.size() == 0) chk(1'b0, "R2", "unexpected done", cyc, -1);
        else begin
          r = rq.pop_front();
          chk(fail == r.fl, r.tag, "fail flag", int'(fail), int'(r.fl));
          chk(int'(count) == r.cnt, r.tag, "count", int'(count), r.cnt);
          chk(cyc == r.due, "R2", "done cycle", cyc, r.due);
        end
      end
    end
  end

  task automatic push_wr(int a, int m, string tag, inout int nb);
    ref_ram[a] = ref_ram[a] ^ 8'(m);
    wq.push_back('{a, int'(ref_ram[a]), tag});
    nb++;
  endtask

  task automatic run_job(int n, int p[NE], int t[NE]);
    int    nb = 0;
    bit    f  = 1'b0;
    string rt = "R10";
    int    mism = 0;
    if (n > NE) begin
      f  = 1'b1;
      rt = "R12";
    end else begin
      for (int k = 0; k < n; k++) begin
        if (p[k] > MAXP) begin
          f  = 1'b1;
          rt = (k > 0) ? "R9" : "R8";
          break;
        end
        if (p[k] == 0 && t[k] > 255) begin
          f  = 1'b1;
          rt = (k > 0) ? "R9" : "R5";
          break;
        end
        if (p[k] == 0) begin
          push_wr(0, t[k] & 255, "R5", nb);
        end else if (p[k] == 1365) begin
          push_wr(2047, t[k] >> 4, "R6", nb);
          push_wr(2048, (t[k] << 4) & 255, "R6", nb);
        end else if (p[k] > 1365) begin
          if (p[k] % 2 == 1) begin
            push_wr(2048 + (3*p[k]/2 - 2048), t[k] >> 4, "R7", nb);
            push_wr(2048 + (3*p[k]/2 - 2047), (t[k] << 4) & 255, "R7", nb);
          end else begin
            push_wr(2048 + (3*p[k]/2 - 2049), t[k] >> 8, "R7", nb);
            push_wr(2048 + (3*p[k]/2 - 2048), t[k] & 255, "R7", nb);
          end
        end else if (p[k] % 2 == 1) begin
          push_wr(3*p[k]/2, t[k] >> 4, "R3", nb);
          push_wr(3*p[k]/2 + 1, (t[k] << 4) & 255, "R3", nb);
        end else begin
          push_wr(3*p[k]/2 - 1, t[k] >> 8, "R4", nb);
          push_wr(3*p[k]/2, t[k] & 255, "R4", nb);
        end
      end
    end
    rq.push_back('{f, f ? 0 : n, cyc + 2 + 2*nb, rt});
    for (int k = 0; k < NE; k++) begin
      pos_v[k] = PW'(p[k]);
      pat_v[k] = 12'(t[k]);
    end
    num   = CW'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (rq.size() != 0) @(negedge clk);
    for (int i = 0; i < TOTAL; i++) if (ram[i] !== ref_ram[i]) mism++;
    chk(mism == 0, (rt == "R9") ? "R9" : "R11", "buffer mismatches", mism, 0);
    repeat (3) @(negedge clk);
    chk(fail == f && int'(count) == (f ? 0 : n), "R10", "result held", int'(count), f ? 0 : n);
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    num   = '0;
    pos_v = '0;
    pat_v = '0;
    for (int i = 0; i < TOTAL; i++) begin
      ram[i]     = 8'(i * 37 + 5);
      ref_ram[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !mem_en && count == '0, "R1", "reset state",
        {busy, done, fail, mem_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_en, "R1", "idle after reset", {busy, done, mem_en}, 0);

    run_job(0, '{0, 0, 0, 0}, '{0, 0, 0, 0});                         // R10 empty job
    run_job(2, '{1, 2, 0, 0}, '{12'hABC, 12'h5D3, 0, 0});             // R3 R4 shared byte
    run_job(4, '{0, 1365, 1366, 1374}, '{12'h0A5, 12'hABC, 12'h7E1, 12'hF0F}); // R5 R6 R7
    run_job(2, '{1367, 1364, 0, 0}, '{12'h123, 12'hFED, 0, 0});       // R7 R4
    run_job(3, '{5, 1375, 7, 0}, '{12'h111, 12'h222, 12'h333, 0});    // R9 partial
    run_job(1, '{0, 0, 0, 0}, '{12'h1FF, 0, 0, 0});                   // R5 fail
    run_job(1, '{2047, 0, 0, 0}, '{12'h001, 0, 0, 0});                // R8
    run_job(5, '{3, 4, 5, 6}, '{1, 2, 3, 4});                         // R12
    run_job(4, '{9, 9, 9, 9}, '{12'h0F0, 12'h00F, 12'hF00, 12'h0F0}); // repeated position

    for (int r = 0; r < 25; r++) begin
      int n;
      int p[NE];
      int t[NE];
      n = $urandom_range(0, NE);
      for (int k = 0; k < NE; k++) begin
        p[k] = ($urandom_range(0, 30) == 0) ? $urandom_range(1375, 2047) : $urandom_range(0, MAXP);
        t[k] = $urandom_range(0, 4095);
        if (p[k] == 0 && $urandom_range(0, 1) == 0) t[k] = t[k] & 255;
      end
      run_job(n, p, t);
    end

    chk(wq.size() == 0, "R11", "leftover writes", wq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule